// File: doc/BRIEF.md
# Dual-Law SPI Clock Prescaler

This block turns the module clock into the timing references that an SPI shift engine needs. Its divider runs under one of two laws, chosen by a single select bit. The linear law gives an SCK period of 2×(N+1) module cycles. The power-of-two law gives an SCK period of 2^M module cycles. The block sends out four signals:

- a one-cycle half-period enable (`sck_tick`);
- a 50% duty square wave that starts low (`sck_lvl`);
- a marker on the enables where that wave goes high (`sck_rise`);
- a capture strobe (`samp_stb`), placed by one of three sample-timing modes so that receive data can still be captured correctly at high serial rates.

The divider setting and the sample mode are sampled only at half-period boundaries. Software may therefore rewrite them while a transfer runs, and no shortened SCK phase appears. While the bus is disabled the divider is held in its idle state: counter cleared, SCK low, no enables. During that time it tracks the live configuration, so the first half period after enabling already uses the current setting.

Top module: `spi_clk_div`

## Requirements
- R1: While `rst` is high, or while `bus_en` was low at the last clock edge, `sck_tick`, `sck_lvl`, `sck_rise` and `samp_stb` are all 0.
- R2: With `div_cfg[12]`=1 the half period is N+1 module cycles, where N=`div_cfg[7:0]`, so the SCK period is 2×(N+1).
- R3: With `div_cfg[12]`=0 and M=`div_cfg[11:8]`≥1, the half period is 2^(M-1) cycles, so the SCK period is 2^M.
- R4: With the power-of-two law and M=0 (and likewise M=1), `sck_tick` is high on every enabled cycle.
- R5: `sck_lvl` toggles exactly on each `sck_tick`, giving 50% duty. `sck_rise` is high only on ticks where `sck_lvl` becomes 1.
- R6: A change of `div_cfg` takes effect only at the next half-period boundary. The half period in progress completes with its old length.
- R7: Normal sampling applies when `smp_norm`=1, and it wins over `smp_late`. `samp_stb` then pulses together with every `sck_rise`.
- R8: Half-cycle-delayed sampling applies when `smp_norm`=0 and `smp_late`=0. `samp_stb` then pulses on every tick where `sck_lvl` returns to 0.
- R9: One-cycle-delayed sampling applies when `smp_norm`=0 and `smp_late`=1. `samp_stb` then pulses with each `sck_rise` except the first one after enabling, which is one full SCK period late.
- R10: A change of the sample-mode inputs is taken at a half-period boundary. It governs the strobes of the ticks that follow that boundary.
- R11: After `bus_en` rises, the first `sck_tick` comes on the L-th enabled cycle, where L is the half period. `sck_lvl` starts at 0, so the first tick is a rising one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Divider run enable; holds the idle state when low |
| div_cfg | input | 13 | [7:0] linear N, [11:8] exponent M, [12] law select (1 = linear) |
| smp_norm | input | 1 | Selects normal sampling (priority) |
| smp_late | input | 1 | Selects one-cycle-delayed sampling when `smp_norm` is low |
| sck_tick | output | 1 | Registered half-period enable |
| sck_lvl | output | 1 | Registered 50% duty SCK level |
| sck_rise | output | 1 | Tick on which `sck_lvl` goes high |
| samp_stb | output | 1 | Registered receive capture strobe |

## Verification
Several properties are checked on every cycle:

- the idle state while the bus is off;
- the level changing only and always on a tick;
- rising markers implying a tick and a high level;
- strobes occurring only on ticks.

Only the bench scenarios can show the exact half-period lengths under both laws, and the deferred reload when the divider or mode is rewritten mid-period. The same holds for strobe placement in each sample mode, including the skipped first strobe of the delayed mode. For these the bench compares against a schedule it derives from the configuration it drives.

// File: rtl/spi_div_pkg.sv
package spi_div_pkg;

  typedef enum logic [1:0] {
    SMP_HALF = 2'd0,
    SMP_NORM = 2'd1,
    SMP_LATE = 2'd2
  } smp_mode_e;

  // Normal sampling has priority over the late request.
  function automatic smp_mode_e pick_mode(input logic norm, input logic late);
    if (norm)      return SMP_NORM;
    else if (late) return SMP_LATE;
    else           return SMP_HALF;
  endfunction

endpackage

// File: rtl/spi_div_law.sv
module spi_div_law #(
  parameter int N_W    = 8,
  parameter int M_W    = 4,
  parameter int HALF_W = 15,
  localparam int CFG_W = N_W + M_W + 1
) (
  input  logic [CFG_W-1:0]  cfg,
  output logic [HALF_W-1:0] half_m1
);

  logic [N_W-1:0]    lin_n;
  logic [M_W-1:0]    pow_m;
  logic              lin_sel;
  logic [HALF_W-1:0] lin_half;
  logic [HALF_W-1:0] pow_half;
  logic [HALF_W-1:0] one_v;

  assign lin_n   = cfg[N_W-1:0];
  assign pow_m   = cfg[N_W+M_W-1:N_W];
  assign lin_sel = cfg[N_W+M_W];
  assign one_v   = {{(HALF_W-1){1'b0}}, 1'b1};

  generate
    if (HALF_W > N_W) begin : g_ext
      assign lin_half = {{(HALF_W-N_W){1'b0}}, lin_n};
    end else begin : g_fit
      assign lin_half = lin_n[HALF_W-1:0];
    end
  endgenerate

  // Half period minus one: 2^(M-1)-1 for M>=1, zero (every cycle) for M=0.
  always_comb begin
    if (pow_m == '0) pow_half = '0;
    else             pow_half = (one_v << (pow_m - 1'b1)) - one_v;
  end

  assign half_m1 = lin_sel ? lin_half : pow_half;

endmodule

// File: rtl/spi_div_count.sv
module spi_div_count
  import spi_div_pkg::*;
#(
  parameter int HALF_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic [HALF_W-1:0] half_in,
  input  smp_mode_e         mode_in,
  output logic              wrap,
  output logic              lvl_q,
  output smp_mode_e         mode_q,
  output logic              tick_q,
  output logic              rise_q
);

  logic [HALF_W-1:0] cnt_q;
  logic [HALF_W-1:0] half_q;

  assign wrap = (cnt_q == half_q);

  always_ff @(posedge clk) begin
    if (rst || !bus_en) begin
      cnt_q  <= '0;
      lvl_q  <= 1'b0;
      tick_q <= 1'b0;
      rise_q <= 1'b0;
      half_q <= half_in;
      mode_q <= mode_in;
    end else begin
      tick_q <= wrap;
      rise_q <= wrap && !lvl_q;
      if (wrap) begin
        cnt_q  <= '0;
        lvl_q  <= !lvl_q;
        half_q <= half_in;
        mode_q <= mode_in;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/spi_div_sample.sv
module spi_div_sample
  import spi_div_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      bus_en,
  input  logic      wrap,
  input  logic      lvl_q,
  input  smp_mode_e mode_q,
  output logic      stb_q
);

  logic seen_rise_q;
  logic hit;

  always_comb begin
    unique case (mode_q)
      SMP_NORM: hit = !lvl_q;
      SMP_LATE: hit = !lvl_q && seen_rise_q;
      default:  hit = lvl_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !bus_en) begin
      stb_q       <= 1'b0;
      seen_rise_q <= 1'b0;
    end else begin
      stb_q <= wrap && hit;
      if (wrap && !lvl_q) seen_rise_q <= 1'b1;
    end
  end

endmodule

// File: rtl/spi_clk_div.sv
module spi_clk_div
  import spi_div_pkg::*;
#(
  parameter int N_W = 8,
  parameter int M_W = 4,
  localparam int CFG_W  = N_W + M_W + 1,
  localparam int POW_W  = (1 << M_W) - 1,
  localparam int HALF_W = (POW_W > N_W + 1) ? POW_W : N_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_en,
  input  logic [CFG_W-1:0] div_cfg,
  input  logic             smp_norm,
  input  logic             smp_late,
  output logic             sck_tick,
  output logic             sck_lvl,
  output logic             sck_rise,
  output logic             samp_stb
);

  logic [HALF_W-1:0] half_live;
  smp_mode_e         mode_live;
  smp_mode_e         mode_cur;
  logic              wrap;

  assign mode_live = pick_mode(smp_norm, smp_late);

  spi_div_law #(.N_W(N_W), .M_W(M_W), .HALF_W(HALF_W)) u_law (
    .cfg     (div_cfg),
    .half_m1 (half_live)
  );

  spi_div_count #(.HALF_W(HALF_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .bus_en  (bus_en),
    .half_in (half_live),
    .mode_in (mode_live),
    .wrap    (wrap),
    .lvl_q   (sck_lvl),
    .mode_q  (mode_cur),
    .tick_q  (sck_tick),
    .rise_q  (sck_rise)
  );

  spi_div_sample u_smp (
    .clk    (clk),
    .rst    (rst),
    .bus_en (bus_en),
    .wrap   (wrap),
    .lvl_q  (sck_lvl),
    .mode_q (mode_cur),
    .stb_q  (samp_stb)
  );

endmodule

// File: rtl/spi_clk_div_chk.sv
module spi_clk_div_chk (
  input logic clk,
  input logic rst,
  input logic bus_en,
  input logic sck_tick,
  input logic sck_lvl,
  input logic sck_rise,
  input logic samp_stb
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_en) |-> (!sck_tick && !sck_lvl && !sck_rise && !samp_stb)); // R1

  AST_TICK_TOGGLES: assert property (@(posedge clk) disable iff (rst)
    sck_tick |-> (sck_lvl != $past(sck_lvl))); // R5

  AST_LVL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_en) && !sck_tick) |-> $stable(sck_lvl)); // R5

  AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    sck_rise |-> (sck_tick && sck_lvl)); // R5

  AST_STB_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    samp_stb |-> sck_tick); // R7

endmodule

bind spi_clk_div spi_clk_div_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_en   (bus_en),
  .sck_tick (sck_tick),
  .sck_lvl  (sck_lvl),
  .sck_rise (sck_rise),
  .samp_stb (samp_stb)
);

// File: tb/spi_clk_div_tb.sv
module spi_clk_div_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        bus_en;
  logic [12:0] div_cfg;
  logic        smp_norm;
  logic        smp_late;
  logic        sck_tick, sck_lvl, sck_rise, samp_stb;

  int errs = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;
  string tag = "R1";

  // bench schedule state
  int k, nxt, j, mmode;

  always #5 clk = ~clk;

  spi_clk_div u_dut (
    .clk(clk), .rst(rst), .bus_en(bus_en), .div_cfg(div_cfg),
    .smp_norm(smp_norm), .smp_late(smp_late),
    .sck_tick(sck_tick), .sck_lvl(sck_lvl), .sck_rise(sck_rise), .samp_stb(samp_stb)
  );

  function automatic int half_len(input logic [12:0] c);
    if (c[12]) return int'(c[7:0]) + 1;
    if (c[11:8] == 4'd0) return 1;
    return 1 << (int'(c[11:8]) - 1);
  endfunction

  // 0 normal, 1 half delay, 2 one-cycle delay
  function automatic int mode_of(input logic n, input logic l);
    if (n) return 0;
    if (l) return 2;
    return 1;
  endfunction

  function automatic bit stb_rule(input int md, input int jn);
    if (md == 0) return (jn % 2) == 1;
    if (md == 1) return (jn % 2) == 0;
    return ((jn % 2) == 1) && (jn >= 3);
  endfunction

  function automatic string stb_tag(input int md);
    if (md == 0) return "R7";
    if (md == 1) return "R8";
    return "R9";
  endfunction

  task automatic check(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s at cycle %0d: actual=%b expected=%b", req, what, cycles, act, exp);
    end
  endtask

  task automatic cyc();
    bit e_tick, e_rise, e_stb, e_lvl;
    int md_used;
    int ln, md;
    @(posedge clk);
    ln = half_len(div_cfg);
    md = mode_of(smp_norm, smp_late);
    e_tick = 0; e_rise = 0; e_stb = 0;
    md_used = mmode;
    if (rst || !bus_en) begin
      k = 0; nxt = ln - 1; j = 0; mmode = md;
    end else begin
      if (k == nxt) begin
        e_tick = 1;
        j++;
        e_rise = (j % 2) == 1;
        e_stb = stb_rule(md_used, j);
        nxt = k + ln;
        mmode = md;
      end
      k++;
    end
    e_lvl = (j % 2) == 1;
    #2;
    cycles++;
    if (rst || !bus_en) begin
      check(sck_tick, 1'b0, "R1", "tick idle");
      check(sck_lvl,  1'b0, "R1", "lvl idle");
      check(samp_stb, 1'b0, "R1", "stb idle");
    end else begin
      check(sck_tick, e_tick, tag, "tick");
      check(sck_lvl,  e_lvl,  "R5", "lvl");
      check(sck_rise, e_rise, "R5", "rise");
      check(samp_stb, e_stb,  (tag == "R10") ? "R10" : stb_tag(md_used), "stb");
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic start(input logic [12:0] c, input logic n, input logic l, input string t);
    bus_en = 0; div_cfg = c; smp_norm = n; smp_late = l; tag = t;
    run(2);
    bus_en = 1;
  endtask

  initial begin
    rst = 1; bus_en = 0; div_cfg = 13'h1000; smp_norm = 1; smp_late = 0;
    void'($urandom(32'd1234));
    tag = "R1";
    run(4);
    rst = 0;
    run(3);

    // R2 linear law
    start(13'h1000, 1, 0, "R2"); run(10);
    start(13'h1003, 1, 0, "R2"); run(30);
    start(13'h10FF, 1, 0, "R2"); run(1030);
    // R3/R4 power-of-two law
    start(13'h0000, 1, 0, "R4"); run(12);
    start(13'h0100, 0, 0, "R4"); run(12);
    start(13'h0300, 1, 0, "R3"); run(40);
    start(13'h0F00, 1, 0, "R3"); run(2*16384 + 10);
    // R7 R8 R9 sample modes
    start(13'h1002, 1, 1, "R7"); run(40);
    start(13'h1002, 0, 0, "R8"); run(40);
    start(13'h1002, 0, 1, "R9"); run(40);
    // R11 first tick after enable
    start(13'h1004, 1, 0, "R11"); run(25);
    // R6 divider rewrite mid half-period
    start(13'h1009, 1, 0, "R6"); run(13);
    div_cfg = 13'h1002; run(40);
    div_cfg = 13'h0500; run(7);
    div_cfg = 13'h0200; run(60);
    // R10 mode rewrite mid-run
    start(13'h1003, 1, 0, "R10"); run(10);
    smp_norm = 0; smp_late = 0; run(20);
    smp_late = 1; run(30);
    // R1 disable mid-run
    tag = "R1"; bus_en = 0; run(5);

    // constrained random mix
    for (int it = 0; it < 40; it++) begin
      logic [12:0] c;
      c[12]   = $urandom_range(1, 0);
      c[7:0]  = 8'($urandom_range(20, 0));
      c[11:8] = 4'($urandom_range(6, 0));
      start(c, 1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)), c[12] ? "R2" : "R3");
      run($urandom_range(150, 10));
      if ($urandom_range(1, 0) == 1) begin
        tag = "R6";
        div_cfg[7:0]  = 8'($urandom_range(20, 0));
        div_cfg[11:8] = 4'($urandom_range(6, 0));
        smp_norm = 1'($urandom_range(1, 0));
        smp_late = 1'($urandom_range(1, 0));
        run($urandom_range(120, 10));
      end
      if ($urandom_range(4, 0) == 0) begin
        tag = "R1"; bus_en = 0; run(3);
      end
    end

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int w;
    w = 0;
    while (w < 190000) begin
      @(posedge clk);
      w++;
    end
    if (!done) begin
      done = 1;
      errs++;
      checks++;
      $display("FAIL watchdog expired at cycle %0d: actual=running expected=finished", cycles);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule